// File: doc/BRIEF.md
# Triggered Test Burst Generator

This block is a stimulus source for exercising a gated timing counter on the bench. One trigger edge starts a sequence. A train of single-cycle pulses at a fixed channel spacing begins a short fixed lead after the trigger. The train is locked in phase to the trigger and has no jitter. An internal stop strobe fires after a delay chosen by a small code. The train then closes a fixed tail after that stop. A one-cycle done strobe marks the end of the burst, so a checker downstream can compare the number of pulses it counted with the number it expected.

The delay code is mapped to a cycle count by a square law, min(MIN_DELAY + code² · STEP, MAX_DELAY). Low codes therefore step the stop time finely and high codes step it coarsely. The result saturates at a window of 1000 cycles, which is 10 µs at a 10 ns channel. The stop strobe is a port of its own so that a sequencer can take it as its stop event in test mode. The code is captured when the trigger is accepted. A trigger that arrives while a burst runs is ignored. MIN_DELAY must be at least LEAD.

Top module: `test_burst_gen`

## Requirements
- R1: While reset is asserted and while no burst is running, burstPulse, intStop and burstDone are all low.
- R2: A burst starts only on a rising edge of trigger sampled while the block is idle. A trigger held high after that edge starts nothing further.
- R3: Index 0 is the first cycle after the accepting clock edge. intStop is high for exactly one cycle, at index S = min(MIN_DELAY + code²·STEP, MAX_DELAY), with defaults MIN_DELAY=4, STEP=1, MAX_DELAY=1000.
- R4: burstPulse is high for single cycles at indices LEAD, LEAD+CHAN, LEAD+2·CHAN, and so on, none later than S+TAIL. The count is (S+TAIL−LEAD)/CHAN+1, with defaults LEAD=2, CHAN=2, TAIL=1.
- R5: burstDone is high for exactly one cycle, at index S+TAIL. After that the block is idle and a later trigger edge starts a new burst.
- R6: A trigger edge that arrives while a burst is running has no effect on that burst, and no second burst follows.
- R7: delayCode is captured at acceptance. Changing it during a burst does not move the stop.
- R8: A trigger edge while enable is low starts nothing.
- R9: Code 0 gives the shortest burst (S=4, two pulses). Any code whose square law exceeds the window gives S=MAX_DELAY (codes 32 and 63 both give 1000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Permits acceptance of a trigger |
| trigger | input | 1 | Start request, rising edge |
| delayCode | input | CODE_W (6) | Stop delay code, square-law mapped |
| burstPulse | output | 1 | Burst pulse train |
| intStop | output | 1 | Internal stop strobe |
| burstDone | output | 1 | One-cycle end-of-burst strobe |

## Verification
A wrong elapsed count or a wrong captured stop value shows up within the same burst. The stop strobe lands at the wrong index, and the done strobe and the pulse count move with it. A phase counter that is off shifts the first pulse away from index 2 or changes the count by one. A control state that fails to clear or to hold either leaves the outputs quiet after a trigger or lets a second train start. The bench catches this in the cycles right after done, or at the stray trigger itself.

// File: rtl/tbg_pkg.sv
package tbg_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture code, clear counters
    logic active;  // burst in progress
  } dpCtl_t;

endpackage

// File: rtl/tbg_delay_map.sv
module tbg_delay_map #(
  parameter int CODE_W    = 6,
  parameter int CNT_W     = 10,
  parameter int MIN_DELAY = 4,
  parameter int STEP      = 1,
  parameter int MAX_DELAY = 1000
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  cycles
);

  localparam int WIDE_W = 2 * CODE_W + $clog2(STEP + 1) + CNT_W + 1;

  logic [WIDE_W-1:0] codeWide;
  logic [WIDE_W-1:0] rawCycles;
  logic              overWindow;

  assign codeWide   = WIDE_W'(code);
  // square law: fine steps near zero, coarse steps near the window end
  assign rawCycles  = WIDE_W'(MIN_DELAY) + codeWide * codeWide * WIDE_W'(STEP);
  assign overWindow = rawCycles > WIDE_W'(MAX_DELAY);
  assign cycles     = overWindow ? CNT_W'(MAX_DELAY) : rawCycles[CNT_W-1:0];

endmodule

// File: rtl/tbg_ctrl.sv
module tbg_ctrl
  import tbg_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   enable,
  input  logic   trigger,
  input  logic   atEnd,
  output dpCtl_t ctl,
  output logic   burstDone
);

  logic trigPrev;
  logic active;
  logic trigEdge;
  logic accept;
  logic finish;

  assign trigEdge = trigger & ~trigPrev;
  assign accept   = ~active & enable & trigEdge;
  assign finish   = active & atEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigPrev <= 1'b0;
      active   <= 1'b0;
    end else begin
      trigPrev <= trigger;
      if (accept)      active <= 1'b1;
      else if (finish) active <= 1'b0;
    end
  end

  assign ctl.load   = accept;
  assign ctl.active = active;
  assign burstDone  = finish;

  assert_done_closes_R5: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !active);

  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (active && !atEnd) |=> active);

  assert_start_needs_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> $past(enable));

endmodule

// File: rtl/tbg_datapath.sv
module tbg_datapath
  import tbg_pkg::*;
#(
  parameter int CODE_W    = 6,
  parameter int CNT_W     = 10,
  parameter int MIN_DELAY = 4,
  parameter int STEP      = 1,
  parameter int MAX_DELAY = 1000,
  parameter int LEAD      = 2,
  parameter int TAIL      = 1,
  parameter int CHAN      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [CODE_W-1:0] code,
  output logic              burstPulse,
  output logic              intStop,
  output logic              atEnd
);

  localparam int PH_W = (CHAN > 1) ? $clog2(CHAN) : 1;

  logic [CNT_W-1:0] mappedStop;
  logic [CNT_W-1:0] stopAt;
  logic [CNT_W-1:0] endAt;
  logic [CNT_W-1:0] elapsed;
  logic [PH_W-1:0]  phase;
  logic             inWindow;

  tbg_delay_map #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .MIN_DELAY(MIN_DELAY),
    .STEP(STEP), .MAX_DELAY(MAX_DELAY)
  ) mapInst (
    .code  (code),
    .cycles(mappedStop)
  );

  assign endAt    = stopAt + CNT_W'(TAIL);
  assign atEnd    = elapsed == endAt;
  assign inWindow = ctl.active && (elapsed >= CNT_W'(LEAD));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopAt  <= '0;
      elapsed <= '0;
      phase   <= '0;
    end else if (ctl.load) begin
      stopAt  <= mappedStop;
      elapsed <= '0;
      phase   <= '0;
    end else if (ctl.active && !atEnd) begin
      elapsed <= elapsed + 1'b1;
      if (inWindow) begin
        phase <= (phase == PH_W'(CHAN - 1)) ? '0 : phase + 1'b1;
      end
    end
  end

  assign burstPulse = inWindow && (phase == '0);
  assign intStop    = ctl.active && (elapsed == stopAt);

  assert_stop_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    intStop |=> !intStop);

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.active |-> (!burstPulse && !intStop));

  assert_stop_limit_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.active |-> (stopAt <= CNT_W'(MAX_DELAY)));

  assert_code_latched_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.active |=> (!ctl.active || $stable(stopAt)));

  generate
    if (CHAN > 1) begin : gapCheck
      assert_pulse_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
        burstPulse |=> !burstPulse);
    end
  endgenerate

endmodule

// File: rtl/test_burst_gen.sv
module test_burst_gen
  import tbg_pkg::*;
#(
  parameter int CODE_W    = 6,
  parameter int MIN_DELAY = 4,
  parameter int STEP      = 1,
  parameter int MAX_DELAY = 1000,
  parameter int LEAD      = 2,
  parameter int TAIL      = 1,
  parameter int CHAN      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              trigger,
  input  logic [CODE_W-1:0] delayCode,
  output logic              burstPulse,
  output logic              intStop,
  output logic              burstDone
);

  localparam int CNT_W = $clog2(MAX_DELAY + TAIL + 1);

  dpCtl_t ctl;
  logic   atEnd;

  tbg_ctrl ctrlInst (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .trigger  (trigger),
    .atEnd    (atEnd),
    .ctl      (ctl),
    .burstDone(burstDone)
  );

  tbg_datapath #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .MIN_DELAY(MIN_DELAY), .STEP(STEP),
    .MAX_DELAY(MAX_DELAY), .LEAD(LEAD), .TAIL(TAIL), .CHAN(CHAN)
  ) dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .code      (delayCode),
    .burstPulse(burstPulse),
    .intStop   (intStop),
    .atEnd     (atEnd)
  );

endmodule

// File: tb/tb_test_burst_gen.sv
module tb_test_burst_gen;

  localparam int CODE_W = 6;
  localparam int LEAD   = 2;
  localparam int TAIL   = 1;
  localparam int CHAN   = 2;
  localparam int VEC_N  = 8;
  localparam int vecCode [VEC_N] = '{0, 1, 3, 10, 20, 31, 32, 63};
  localparam int vecStop [VEC_N] = '{4, 5, 13, 104, 404, 965, 1000, 1000};

  logic clk = 0;
  logic rstN = 0;
  logic enable = 0;
  logic trigger = 0;
  logic [CODE_W-1:0] delayCode = '0;
  logic burstPulse, intStop, burstDone;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  test_burst_gen dut (
    .clk(clk), .rstN(rstN), .enable(enable), .trigger(trigger),
    .delayCode(delayCode), .burstPulse(burstPulse), .intStop(intStop),
    .burstDone(burstDone)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expCount(input int s);
    return (s + TAIL - LEAD) / CHAN + 1;
  endfunction

  // Runs one burst: trigger edge, then samples at falling edges, index 0 first
  task automatic runBurst(input int code, input int expStop, input int extraAt,
                          input bit holdTrig, input int swapTo, input string tag);
    int firstP = -1, lastP = -1, nP = 0, stopI = -1, nS = 0, doneI = -1, nD = 0;
    int limit = expStop + TAIL + 20;
    @(negedge clk);
    delayCode = CODE_W'(code);
    trigger = 1'b1;
    @(negedge clk);
    if (!holdTrig) trigger = 1'b0;
    for (int j = 0; j <= limit; j++) begin
      if (burstPulse) begin if (firstP < 0) firstP = j; lastP = j; nP++; end
      if (intStop)    begin if (stopI < 0) stopI = j; nS++; end
      if (burstDone)  begin if (doneI < 0) doneI = j; nD++; end
      trigger = holdTrig || (j == extraAt);
      if (j == 1 && swapTo >= 0) delayCode = CODE_W'(swapTo);
      @(negedge clk);
    end
    trigger = 1'b0;
    check({tag, " R3 stop index"}, stopI, expStop);
    check({tag, " R3 stop count"}, nS, 1);
    check({tag, " R4 first pulse"}, firstP, LEAD);
    check({tag, " R4 pulse count"}, nP, expCount(expStop));
    check({tag, " R4 last pulse bound"}, int'(lastP <= expStop + TAIL), 1);
    check({tag, " R5 done index"}, doneI, expStop + TAIL);
    check({tag, " R5 done count"}, nD, 1);
  endtask

  // Observes a quiet window after an attempted trigger
  task automatic quietWindow(input int cycles, input string tag);
    int seen = 0;
    for (int j = 0; j < cycles; j++) begin
      @(negedge clk);
      seen += int'(burstPulse) + int'(intStop) + int'(burstDone);
    end
    check(tag, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset outputs", int'(burstPulse) + int'(intStop) + int'(burstDone), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle outputs", int'(burstPulse) + int'(intStop) + int'(burstDone), 0);

    // R8: enable low, trigger ignored
    delayCode = CODE_W'(3);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    quietWindow(40, "R8 trigger with enable low");
    enable = 1'b1;

    // Vector table: R3 R4 R5 R9 across the code range
    for (int v = 0; v < VEC_N; v++) begin
      runBurst(vecCode[v], vecStop[v], -1, 1'b0, -1, $sformatf("vec%0d", v));
    end

    // R6: extra trigger edge during a burst
    runBurst(10, 104, 20, 1'b0, -1, "R6 retrigger");
    quietWindow(30, "R6 no second burst");

    // R2: held trigger level, one burst only
    runBurst(1, 5, -1, 1'b1, -1, "R2 held trigger");
    quietWindow(30, "R2 no burst after release");

    // R7: code changed mid-burst
    runBurst(3, 13, -1, 1'b0, 40, "R7 code swap");

    // R9: shortest burst again right after a long one
    runBurst(0, 4, -1, 1'b0, -1, "R9 minimum");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule